// File: doc/BRIEF.md
# Dual-Direction Cross-Clock Mailbox

This block passes single data words between two independently clocked ports without going through a queue. Each direction has its own word register and its own active-low "mail waiting" flag. The forward channel carries words from port A to port B. The return channel carries words from port B to port A. A port stores a word for its peer with a qualified mail write on its own clock. The peer sees its flag go low after the event has crossed into its clock domain. The peer then takes the word with a qualified mail read, and that read returns its flag high.

Flag changes cross between the clocks as toggles through two-flop synchronizers, so no event is lost whatever the ratio between the two clocks. The sender keeps a synchronized view of the receiver's read toggle. While that view shows the word as still unread, the sender ignores further mail writes, so the word held in the register never changes under the receiver. One active-low reset, asserted asynchronously, clears both channels.

Top module: `mbx_bridge`

## Requirements
- R1: While `rst_n` is low, both `a_mail_n` and `b_mail_n` are high and both data outputs are zero. Both flags stay high after reset until a mail write is accepted.
- R2: A mail write on port A is accepted at a `clk_a` rising edge when `a_cs_n`=0, `a_wr_rd`=1, `a_en`=1 and `a_mb_sel`=1. It drives `b_mail_n` low after exactly two `clk_b` rising edges that follow that edge, and never after only one.
- R3: A port-A write attempt with any one of the four qualifiers at its inactive value is ignored: `b_mail_n` stays high. The inactive values are `a_cs_n`=1, `a_wr_rd`=0, `a_en`=0 and `a_mb_sel`=0.
- R4: A mail read on port B has the qualifier `b_cs_n`=0, `b_wr_rd`=0, `b_en`=1, `b_mb_sel`=1 with `b_mail_n` low. While that qualifier is true, `b_dout` shows the stored word in the same cycle. The read takes effect at the next `clk_b` rising edge, and after that edge `b_mail_n` is high.
- R5: When the port-B read qualifier is not true, `b_dout` is zero, and a pending flag stays low across the edge.
- R6: While a forward word is unread, or its read has not yet been synchronized back to port A, further port-A mail writes are dropped. The receiver reads the first word, and its flag stays high afterwards. Once the read has crossed back, a new write is accepted again.
- R7: A port-B read attempt while `b_mail_n` is high leaves the flag high, and `b_dout` stays zero.
- R8: The return channel works the same way with the roles swapped: a port-B mail write drives `a_mail_n` low, and a port-A read returns the word on `a_dout` and sets `a_mail_n` high. Activity on one channel does not change the other channel's flag.
- R9: Asserting `rst_n` while mail is pending forces the flag high at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| a_cs_n | input | 1 | Port A select, active low |
| a_wr_rd | input | 1 | Port A direction: 1 write, 0 read |
| a_en | input | 1 | Port A access enable |
| a_mb_sel | input | 1 | Port A mailbox path select |
| a_din | input | DW (36) | Word written by port A into the forward mailbox |
| a_dout | output | DW (36) | Return-mailbox word while port A reads, else zero |
| a_mail_n | output | 1 | Low when return mail waits for port A |
| b_cs_n | input | 1 | Port B select, active low |
| b_wr_rd | input | 1 | Port B direction: 1 write, 0 read |
| b_en | input | 1 | Port B access enable |
| b_mb_sel | input | 1 | Port B mailbox path select |
| b_din | input | DW (36) | Word written by port B into the return mailbox |
| b_dout | output | DW (36) | Forward-mailbox word while port B reads, else zero |
| b_mail_n | output | 1 | Low when forward mail waits for port B |

## Verification
The bench times the flag's fall against the receiving clock. A design with one synchronizer stage too few lowers the flag after a single receiver edge, and a design whose toggle is lost keeps the flag high for good. The bench writes a second word while the first is still unread. A design that fails to block that write either hands out the later word or re-arms the flag after the read. Each write qualifier is removed in turn, and reads are attempted on an empty mailbox, to catch a decoder that ignores a term or a read that toggles without pending mail. A reset in the middle of a transfer and traffic in the reverse direction expose flags that are reset late or channels that are wired across each other.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic [1:0] {
        OP_NONE    = 2'd0,
        OP_MAIL_WR = 2'd1,
        OP_MAIL_RD = 2'd2
    } mbx_op_e;

    // Mailbox access decode shared by both ports
    function automatic mbx_op_e mbx_decode(
        input logic cs_n,
        input logic wr_rd,
        input logic en,
        input logic mb_sel
    );
        mbx_op_e op;
        op = OP_NONE;
        if (!cs_n && en && mb_sel) begin
            op = wr_rd ? OP_MAIL_WR : OP_MAIL_RD;
        end
        return op;
    endfunction

endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
    } sync_st_t;

    sync_st_t st_d, st_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb begin
                st_d    = st_q;
                st_d.sh = din;
            end
        end else begin : g_chain
            always_comb begin
                st_d    = st_q;
                st_d.sh = {st_q.sh[STAGES-2:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.sh[STAGES-1];

endmodule

// File: rtl/mbx_tx.sv
module mbx_tx #(
    parameter int DW = 36
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic [DW-1:0] wr_data,
    input  logic          ack_tgl_sync,
    output logic          mail_tgl,
    output logic [DW-1:0] mail_data
);
    typedef struct packed {
        logic          tgl;
        logic [DW-1:0] word;
    } tx_st_t;

    tx_st_t st_d, st_q;
    logic   busy;

    always_comb begin
        st_d = st_q;
        // a word is outstanding until the receiver's toggle matches ours
        busy = (st_q.tgl != ack_tgl_sync);
        if (wr_req && !busy) begin
            st_d.tgl  = ~st_q.tgl;
            st_d.word = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mail_tgl  = st_q.tgl;
    assign mail_data = st_q.word;

endmodule

// File: rtl/mbx_rx.sv
module mbx_rx #(
    parameter int DW = 36
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_req,
    input  logic          mail_tgl_sync,
    input  logic [DW-1:0] mail_data,
    output logic          flag_n,
    output logic          rd_tgl,
    output logic [DW-1:0] rd_data
);
    typedef struct packed {
        logic tgl;
    } rx_st_t;

    rx_st_t st_d, st_q;
    logic   waiting;
    logic   take;

    always_comb begin
        st_d    = st_q;
        waiting = (mail_tgl_sync != st_q.tgl);
        take    = rd_req && waiting;
        if (take) begin
            st_d.tgl = ~st_q.tgl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_n  = ~waiting;
    assign rd_tgl  = st_q.tgl;
    assign rd_data = take ? mail_data : '0;

endmodule

// File: rtl/mbx_bridge.sv
module mbx_bridge #(
    parameter int DW          = 36,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk_a,
    input  logic          clk_b,
    input  logic          rst_n,
    input  logic          a_cs_n,
    input  logic          a_wr_rd,
    input  logic          a_en,
    input  logic          a_mb_sel,
    input  logic [DW-1:0] a_din,
    output logic [DW-1:0] a_dout,
    output logic          a_mail_n,
    input  logic          b_cs_n,
    input  logic          b_wr_rd,
    input  logic          b_en,
    input  logic          b_mb_sel,
    input  logic [DW-1:0] b_din,
    output logic [DW-1:0] b_dout,
    output logic          b_mail_n
);
    import mbx_pkg::*;

    localparam int NCH = 2; // 0: A to B, 1: B to A

    mbx_op_e op_a, op_b;
    always_comb begin
        op_a = mbx_decode(a_cs_n, a_wr_rd, a_en, a_mb_sel);
        op_b = mbx_decode(b_cs_n, b_wr_rd, b_en, b_mb_sel);
    end

    logic          s_clk   [NCH];
    logic          r_clk   [NCH];
    logic          s_wr    [NCH];
    logic          r_rd    [NCH];
    logic [DW-1:0] s_din   [NCH];
    logic [DW-1:0] r_dout  [NCH];
    logic          r_flag  [NCH];

    always_comb begin
        s_clk[0] = clk_a;  r_clk[0] = clk_b;
        s_clk[1] = clk_b;  r_clk[1] = clk_a;
        s_wr[0]  = (op_a == OP_MAIL_WR);
        s_wr[1]  = (op_b == OP_MAIL_WR);
        r_rd[0]  = (op_b == OP_MAIL_RD);
        r_rd[1]  = (op_a == OP_MAIL_RD);
        s_din[0] = a_din;
        s_din[1] = b_din;
    end

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            logic          m_tgl, m_tgl_sync;
            logic          k_tgl, k_tgl_sync;
            logic [DW-1:0] m_word;

            mbx_tx #(.DW(DW)) u_tx (
                .clk          (s_clk[c]),
                .rst_n        (rst_n),
                .wr_req       (s_wr[c]),
                .wr_data      (s_din[c]),
                .ack_tgl_sync (k_tgl_sync),
                .mail_tgl     (m_tgl),
                .mail_data    (m_word)
            );

            mbx_sync #(.STAGES(SYNC_STAGES)) u_fwd_sync (
                .clk   (r_clk[c]),
                .rst_n (rst_n),
                .din   (m_tgl),
                .dout  (m_tgl_sync)
            );

            mbx_rx #(.DW(DW)) u_rx (
                .clk           (r_clk[c]),
                .rst_n         (rst_n),
                .rd_req        (r_rd[c]),
                .mail_tgl_sync (m_tgl_sync),
                .mail_data     (m_word),
                .flag_n        (r_flag[c]),
                .rd_tgl        (k_tgl),
                .rd_data       (r_dout[c])
            );

            mbx_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
                .clk   (s_clk[c]),
                .rst_n (rst_n),
                .din   (k_tgl),
                .dout  (k_tgl_sync)
            );
        end
    endgenerate

    assign b_dout   = r_dout[0];
    assign b_mail_n = r_flag[0];
    assign a_dout   = r_dout[1];
    assign a_mail_n = r_flag[1];

endmodule

// File: rtl/mbx_bridge_chk.sv
module mbx_bridge_chk #(
    parameter int DW = 36
) (
    input logic          clk_a,
    input logic          clk_b,
    input logic          rst_n,
    input logic          a_cs_n,
    input logic          a_wr_rd,
    input logic          a_en,
    input logic          a_mb_sel,
    input logic [DW-1:0] a_dout,
    input logic          a_mail_n,
    input logic          b_cs_n,
    input logic          b_wr_rd,
    input logic          b_en,
    input logic          b_mb_sel,
    input logic [DW-1:0] b_dout,
    input logic          b_mail_n
);
    logic a_rd, b_rd;
    assign a_rd = !a_cs_n && !a_wr_rd && a_en && a_mb_sel;
    assign b_rd = !b_cs_n && !b_wr_rd && b_en && b_mb_sel;

    assert_reset_flags_R1: assert property (@(posedge clk_a)
        !rst_n |-> (a_mail_n && b_mail_n));

    assert_read_clears_R4: assert property (@(posedge clk_b) disable iff (!rst_n)
        (b_rd && !b_mail_n) |=> b_mail_n);

    assert_idle_dout_R5: assert property (@(posedge clk_b) disable iff (!rst_n)
        (b_mail_n || !b_rd) |-> (b_dout == '0));

    assert_mail_held_R6: assert property (@(posedge clk_b) disable iff (!rst_n)
        (!b_mail_n && !b_rd) |=> !b_mail_n);

    assert_ret_read_clears_R8: assert property (@(posedge clk_a) disable iff (!rst_n)
        (a_rd && !a_mail_n) |=> a_mail_n);

    assert_ret_mail_held_R8: assert property (@(posedge clk_a) disable iff (!rst_n)
        (!a_mail_n && !a_rd) |=> !a_mail_n);

endmodule

bind mbx_bridge mbx_bridge_chk #(.DW(DW)) u_chk (
    .clk_a    (clk_a),
    .clk_b    (clk_b),
    .rst_n    (rst_n),
    .a_cs_n   (a_cs_n),
    .a_wr_rd  (a_wr_rd),
    .a_en     (a_en),
    .a_mb_sel (a_mb_sel),
    .a_dout   (a_dout),
    .a_mail_n (a_mail_n),
    .b_cs_n   (b_cs_n),
    .b_wr_rd  (b_wr_rd),
    .b_en     (b_en),
    .b_mb_sel (b_mb_sel),
    .b_dout   (b_dout),
    .b_mail_n (b_mail_n)
);

// File: tb/mbx_bridge_tb.sv
`timescale 1ns/100ps
module mbx_bridge_tb;
    localparam int DW = 36;

    logic clk_a = 1'b0, clk_b = 1'b0, rst_n = 1'b0;
    logic a_cs_n = 1'b1, a_wr_rd = 1'b0, a_en = 1'b0, a_mb_sel = 1'b0;
    logic b_cs_n = 1'b1, b_wr_rd = 1'b0, b_en = 1'b0, b_mb_sel = 1'b0;
    logic [DW-1:0] a_din = '0, b_din = '0, a_dout, b_dout;
    logic a_mail_n, b_mail_n;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #2.0 clk_a = ~clk_a;   // 250 MHz
    always #3.5 clk_b = ~clk_b;   // unrelated receiver clock

    mbx_bridge #(.DW(DW)) u_dut (.*);

    task automatic check(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic a_drive(input logic cs_n, input logic wr_rd, input logic en, input logic sel, input logic [DW-1:0] d);
        @(negedge clk_a);
        a_cs_n = cs_n; a_wr_rd = wr_rd; a_en = en; a_mb_sel = sel; a_din = d;
        @(posedge clk_a);
        #0.5;
        a_cs_n = 1'b1; a_wr_rd = 1'b0; a_en = 1'b0; a_mb_sel = 1'b0;
    endtask

    task automatic b_drive(input logic cs_n, input logic wr_rd, input logic en, input logic sel, input logic [DW-1:0] d);
        @(negedge clk_b);
        b_cs_n = cs_n; b_wr_rd = wr_rd; b_en = en; b_mb_sel = sel; b_din = d;
        @(posedge clk_b);
        #0.5;
        b_cs_n = 1'b1; b_wr_rd = 1'b0; b_en = 1'b0; b_mb_sel = 1'b0;
    endtask

    // port-B read, checking data during the qualifier and the flag after the edge
    task automatic b_read(input logic [DW-1:0] exp, input string tag);
        @(negedge clk_b);
        b_cs_n = 1'b0; b_wr_rd = 1'b0; b_en = 1'b1; b_mb_sel = 1'b1;
        #0.5;
        check(b_dout == exp, {tag, " R4 b_dout during read"}, b_dout, exp);
        @(posedge clk_b);
        #0.5;
        b_cs_n = 1'b1; b_en = 1'b0; b_mb_sel = 1'b0;
        check(b_mail_n == 1'b1, {tag, " R4 flag high after read"}, DW'(b_mail_n), DW'(1));
    endtask

    task automatic wait_b(input int n);
        repeat (n) @(posedge clk_b);
        #0.5;
    endtask

    task automatic wait_a(input int n);
        repeat (n) @(posedge clk_a);
        #0.5;
    endtask

    task automatic t_reset();
        #0.5;
        check(a_mail_n && b_mail_n, "R1 flags during reset", DW'({a_mail_n, b_mail_n}), DW'(3));
        check(a_dout == '0 && b_dout == '0, "R1 data zero during reset", b_dout, '0);
        #20.3 rst_n = 1'b1;
        wait_b(4);
        check(a_mail_n && b_mail_n, "R1 flags after reset", DW'({a_mail_n, b_mail_n}), DW'(3));
    endtask

    task automatic t_forward();
        logic [DW-1:0] w = 36'h9_A5C3_0F71;
        a_drive(1'b0, 1'b1, 1'b1, 1'b1, w);
        check(b_mail_n == 1'b1, "R2 flag high right after write", DW'(b_mail_n), DW'(1));
        @(posedge clk_b); #0.5;
        check(b_mail_n == 1'b1, "R2 flag still high after one edge", DW'(b_mail_n), DW'(1));
        @(posedge clk_b); #0.5;
        check(b_mail_n == 1'b0, "R2 flag low after two edges", DW'(b_mail_n), DW'(0));
        check(b_dout == '0, "R5 dout zero while not reading", b_dout, '0);
        b_drive(1'b1, 1'b0, 1'b1, 1'b1, '0);
        check(b_mail_n == 1'b0, "R5 deselected read keeps flag", DW'(b_mail_n), DW'(0));
        b_drive(1'b0, 1'b0, 1'b0, 1'b1, '0);
        check(b_mail_n == 1'b0, "R5 disabled read keeps flag", DW'(b_mail_n), DW'(0));
        check(a_mail_n == 1'b1, "R8 other flag untouched", DW'(a_mail_n), DW'(1));
        b_read(w, "fwd");
        wait_a(4);
    endtask

    task automatic t_qualifiers();
        a_drive(1'b1, 1'b1, 1'b1, 1'b1, 36'h1);
        a_drive(1'b0, 1'b0, 1'b1, 1'b1, 36'h2);
        a_drive(1'b0, 1'b1, 1'b0, 1'b1, 36'h3);
        a_drive(1'b0, 1'b1, 1'b1, 1'b0, 36'h4);
        wait_b(4);
        check(b_mail_n == 1'b1, "R3 unqualified writes ignored", DW'(b_mail_n), DW'(1));
    endtask

    task automatic t_empty_read();
        @(negedge clk_b);
        b_cs_n = 1'b0; b_wr_rd = 1'b0; b_en = 1'b1; b_mb_sel = 1'b1;
        #0.5;
        check(b_dout == '0, "R7 dout zero on empty read", b_dout, '0);
        @(posedge clk_b); #0.5;
        b_cs_n = 1'b1; b_en = 1'b0; b_mb_sel = 1'b0;
        check(b_mail_n == 1'b1, "R7 empty read keeps flag high", DW'(b_mail_n), DW'(1));
        // a toggled read state would make a later write look absent
        a_drive(1'b0, 1'b1, 1'b1, 1'b1, 36'h5_5555_AAAA);
        wait_b(3);
        check(b_mail_n == 1'b0, "R7 later write still raises mail", DW'(b_mail_n), DW'(0));
        b_read(36'h5_5555_AAAA, "empty");
        wait_a(4);
    endtask

    task automatic t_block();
        logic [DW-1:0] w1 = 36'h1_2345_6789, w2 = 36'hF_EDCB_A987, w3 = 36'h0_0F0F_F0F0;
        a_drive(1'b0, 1'b1, 1'b1, 1'b1, w1);
        wait_b(3);
        a_drive(1'b0, 1'b1, 1'b1, 1'b1, w2);
        wait_b(2);
        b_read(w1, "R6 first word kept");
        wait_b(8);
        check(b_mail_n == 1'b1, "R6 blocked write not delivered", DW'(b_mail_n), DW'(1));
        wait_a(4);
        a_drive(1'b0, 1'b1, 1'b1, 1'b1, w3);
        wait_b(3);
        check(b_mail_n == 1'b0, "R6 write accepted after ack", DW'(b_mail_n), DW'(0));
        b_read(w3, "R6 new word");
        wait_a(4);
    endtask

    task automatic t_return();
        logic [DW-1:0] w = 36'hC_3C3C_1234;
        b_drive(1'b0, 1'b1, 1'b1, 1'b1, w);
        wait_a(3);
        check(a_mail_n == 1'b0, "R8 return flag low", DW'(a_mail_n), DW'(0));
        check(b_mail_n == 1'b1, "R8 forward flag untouched", DW'(b_mail_n), DW'(1));
        @(negedge clk_a);
        a_cs_n = 1'b0; a_wr_rd = 1'b0; a_en = 1'b1; a_mb_sel = 1'b1;
        #0.5;
        check(a_dout == w, "R8 return data", a_dout, w);
        @(posedge clk_a); #0.5;
        a_cs_n = 1'b1; a_en = 1'b0; a_mb_sel = 1'b0;
        check(a_mail_n == 1'b1, "R8 return flag high after read", DW'(a_mail_n), DW'(1));
        wait_b(4);
    endtask

    task automatic t_async_reset();
        a_drive(1'b0, 1'b1, 1'b1, 1'b1, 36'h7);
        wait_b(3);
        check(b_mail_n == 1'b0, "R9 mail pending before reset", DW'(b_mail_n), DW'(0));
        #0.7 rst_n = 1'b0;
        #0.2;
        check(b_mail_n == 1'b1, "R9 flag high at once on reset", DW'(b_mail_n), DW'(1));
        #9.9 rst_n = 1'b1;
        wait_b(4);
        check(b_mail_n == 1'b1, "R9 flag high after reset", DW'(b_mail_n), DW'(1));
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_forward();
        t_qualifiers();
        t_empty_read();
        t_block();
        t_return();
        t_async_reset();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule